// File: doc/BRIEF.md
# Big-Endian Sub-Word Data Memory

This block is a synchronous data memory made of 64-bit words. A single request port accepts a byte address, a size code, a write enable and write data. Loads and stores may be 1, 2, 4 or 8 bytes wide. A narrow access uses the byte lane that big-endian ordering gives it: the lowest byte address in a word is the most significant byte.

A narrow store merges its bytes into the stored word and leaves the other bytes as they were. A narrow load returns its lane shifted down to bit 0 and zero-extended. A request whose offset is not a multiple of its width is rejected. It raises an error strobe and changes nothing.

The memory holds 256 words and is cleared by reset. Load data comes out one cycle after the request.

Top module: `be_word_mem`

## Requirements
- R1: The word index is the byte address shifted right by 3. The byte offset is the address ANDed with 7. With 256 words, the address is 11 bits wide and byte address 2047 is the last byte of word 255.
- R2: Size code 0, 1, 2 and 3 selects 1, 2, 4 and 8 bytes. A request is aligned only when its offset ANDed with (bytes − 1) is zero.
- R3: A misaligned request makes `misalign_err` high for exactly one cycle, in the cycle after the request. It does not raise `rd_valid` and changes no memory contents.
- R4: An aligned load of n bytes at offset k returns `(word >> ((8 − n − k)·8))` masked to n·8 bits and zero-extended to 64 bits.
- R5: An aligned store of n bytes at offset k replaces only bits `[(8−k)·8−1 : (8−n−k)·8]` of the word with the low n·8 bits of `wr_data`. All other bytes keep their value, and the upper bits of `wr_data` are ignored.
- R6: An aligned 8-byte store replaces the whole word with `wr_data`.
- R7: Reset clears every word to zero and drives `rd_data`, `rd_valid` and `misalign_err` to zero. A word that has not been written since reset reads as zero, including as the base of a narrow-store merge.
- R8: An aligned load raises `rd_valid` for one cycle and presents its data on `rd_data` in the cycle after the request. A store or a misaligned request leaves `rd_valid` low and `rd_data` unchanged. A store is visible to a load issued in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| req_addr | input | 11 | Byte address |
| req_size | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| req_we | input | 1 | 1 = store, 0 = load |
| wr_data | input | 64 | Store value, right-justified |
| rd_data | output | 64 | Load result, right-justified and zero-extended |
| rd_valid | output | 1 | `rd_data` holds a new load result |
| misalign_err | output | 1 | The previous request was misaligned |

## Verification
Every result of this block is due exactly one clock edge after its request:
- load data and `rd_valid`;
- the error strobe;
- the memory update from a store.

The bench applies each request on a falling edge and samples all three outputs on the next falling edge. At that point the single register stage has just been loaded.

A stored value is checked by a load issued in the very next cycle. This also confirms back-to-back visibility. The one-cycle width of each strobe is covered by checking that both strobes are low again after requests that should not raise them.

// File: rtl/be_mem_pkg.sv
package be_mem_pkg;
    // number of bytes selected by a size code (1 << code)
    function automatic int size_to_bytes(input int code);
        return 1 << code;
    endfunction
endpackage

// File: rtl/be_lane_calc.sv
module be_lane_calc
    import be_mem_pkg::*;
#(
    parameter int WORD_BYTES = 8,
    parameter int OFF_W      = $clog2(WORD_BYTES),
    parameter int SIZE_W     = 2,
    parameter int DATA_W     = WORD_BYTES * 8,
    parameter int SH_W       = $clog2(DATA_W)
) (
    input  logic [OFF_W-1:0]  off_i,
    input  logic [SIZE_W-1:0] size_i,
    output logic [SH_W-1:0]   shift_o,
    output logic [DATA_W-1:0] width_mask_o,
    output logic [DATA_W-1:0] lane_mask_o,
    output logic              misaligned_o
);
    int nbytes_d;
    int shift_d;

    always_comb begin
        nbytes_d     = size_to_bytes(int'(size_i));
        misaligned_o = (int'(size_i) > OFF_W) || ((int'(off_i) & (nbytes_d - 1)) != 0);
        // big-endian lane: lowest address byte sits at the top of the word
        shift_d      = (WORD_BYTES - nbytes_d - int'(off_i)) * 8;
        if (misaligned_o) shift_d = 0;
        shift_o      = SH_W'(shift_d);
        for (int b = 0; b < WORD_BYTES; b++) begin
            width_mask_o[b*8 +: 8] = (b < nbytes_d) ? 8'hFF : 8'h00;
        end
        lane_mask_o  = width_mask_o << shift_o;
    end
endmodule

// File: rtl/be_word_array.sv
module be_word_array #(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 64,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] bit_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we_i) begin
            mem_d[idx_i] = (mem_q[idx_i] & ~bit_en_i) | (wdata_i & bit_en_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata_o = mem_q[idx_i];

    AST_MERGE_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> ((mem_q[$past(idx_i)] & ~$past(bit_en_i)) ==
                  ($past(mem_q[idx_i]) & ~$past(bit_en_i)))); // R5
    AST_MERGE_WRITES_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> ((mem_q[$past(idx_i)] & $past(bit_en_i)) ==
                  ($past(wdata_i) & $past(bit_en_i)))); // R5
endmodule

// File: rtl/be_word_mem.sv
module be_word_mem #(
    parameter int DEPTH      = 256,
    parameter int WORD_BYTES = 8,
    parameter int SIZE_W     = 2,
    parameter int OFF_W      = $clog2(WORD_BYTES),
    parameter int IDX_W      = $clog2(DEPTH),
    parameter int ADDR_W     = IDX_W + OFF_W,
    parameter int DATA_W     = WORD_BYTES * 8,
    parameter int SH_W       = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic              req_we,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              misalign_err
);
    typedef struct packed {
        logic [DATA_W-1:0] rd_data;
        logic              rd_valid;
        logic              err;
    } out_t;

    out_t out_d, out_q;

    logic [IDX_W-1:0]  word_idx;
    logic [OFF_W-1:0]  byte_off;
    logic [SH_W-1:0]   lane_shift;
    logic [DATA_W-1:0] width_mask;
    logic [DATA_W-1:0] lane_mask;
    logic              misaligned;
    logic [DATA_W-1:0] word_rd;
    logic              arr_we;
    logic [DATA_W-1:0] arr_wdata;

    assign word_idx = req_addr[ADDR_W-1:OFF_W];
    assign byte_off = req_addr[OFF_W-1:0];

    be_lane_calc #(
        .WORD_BYTES(WORD_BYTES), .OFF_W(OFF_W), .SIZE_W(SIZE_W),
        .DATA_W(DATA_W), .SH_W(SH_W)
    ) u_lane (
        .off_i(byte_off), .size_i(req_size), .shift_o(lane_shift),
        .width_mask_o(width_mask), .lane_mask_o(lane_mask),
        .misaligned_o(misaligned)
    );

    be_word_array #(.DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_array (
        .clk(clk), .rst_n(rst_n), .we_i(arr_we), .idx_i(word_idx),
        .bit_en_i(lane_mask), .wdata_i(arr_wdata), .rdata_o(word_rd)
    );

    always_comb begin
        arr_we       = req_valid && req_we && !misaligned;
        arr_wdata    = (wr_data & width_mask) << lane_shift;
        out_d        = out_q;
        out_d.rd_valid = 1'b0;
        out_d.err      = req_valid && misaligned;
        if (req_valid && !req_we && !misaligned) begin
            out_d.rd_valid = 1'b1;
            out_d.rd_data  = (word_rd & lane_mask) >> lane_shift;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rd_data      = out_q.rd_data;
    assign rd_valid     = out_q.rd_valid;
    assign misalign_err = out_q.err;

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && misaligned) |=> misalign_err); // R3
    AST_ERR_ONLY_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && misaligned) |=> !misalign_err); // R3
    AST_ERR_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !(misalign_err && rd_valid)); // R3
    AST_LANE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !misaligned) |-> ($countones(lane_mask) == (8 << req_size))); // R2
    AST_LOAD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_we && !misaligned) |=> rd_valid); // R8
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_we) |=> $stable(rd_data)); // R8
endmodule

// File: tb/tb_be_word_mem.sv
module tb_be_word_mem;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [10:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_we = 1'b0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_data;
    logic        rd_valid;
    logic        misalign_err;

    int n_chk = 0;
    int n_fail = 0;
    logic [63:0] model [256];

    always #2 clk = ~clk;

    be_word_mem dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_we(req_we), .wr_data(wr_data),
        .rd_data(rd_data), .rd_valid(rd_valid), .misalign_err(misalign_err)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [63:0] wmask(input int n);
        return (n == 8) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'h1 << (n * 8)) - 64'h1);
    endfunction

    // called at a falling edge; returns at the next falling edge with outputs due
    task automatic issue(input int addr, input int sz, input logic we, input logic [63:0] wd);
        req_valid = 1'b1;
        req_addr  = 11'(addr);
        req_size  = 2'(sz);
        req_we    = we;
        wr_data   = wd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_store(input int addr, input int sz, input logic [63:0] wd);
        int n, off, sh;
        n = 1 << sz; off = addr & 7; sh = (8 - n - off) * 8;
        issue(addr, sz, 1'b1, wd);
        check("R8 store no rd_valid", 64'(rd_valid), 64'h0);
        check("R3 store no err", 64'(misalign_err), 64'h0);
        model[addr >> 3] = (model[addr >> 3] & ~(wmask(n) << sh)) | ((wd & wmask(n)) << sh);
    endtask

    task automatic do_load(input int addr, input int sz, input string req);
        int n, off, sh;
        n = 1 << sz; off = addr & 7; sh = (8 - n - off) * 8;
        issue(addr, sz, 1'b0, 64'hDEAD_BEEF_DEAD_BEEF);
        check("R8 load rd_valid", 64'(rd_valid), 64'h1);
        check(req, rd_data, (model[addr >> 3] >> sh) & wmask(n));
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [63:0] held;
        for (int i = 0; i < 256; i++) model[i] = '0;
        @(negedge clk); @(negedge clk);
        // R7 reset state
        check("R7 rd_valid reset", 64'(rd_valid), 64'h0);
        check("R7 err reset", 64'(misalign_err), 64'h0);
        check("R7 rd_data reset", rd_data, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        do_load(0, 3, "R7 unwritten word zero");
        do_load(2047, 0, "R7 unwritten last byte zero");
        // R7 merge base zero, R5 upper bits ignored
        do_store(8 * 5 + 2, 1, 64'hFFFF_FFFF_FFFF_A1B2);
        do_load(8 * 5, 3, "R7 R5 merge on zero word");
        // R1 boundary words
        do_store(2047, 0, 64'h5A);
        do_load(2040, 3, "R1 last byte in word 255");
        do_store(0, 0, 64'hC3);
        do_load(0, 3, "R1 first byte word 0");
        // R6 full-width replace
        do_store(8 * 9, 3, 64'h0123_4567_89AB_CDEF);
        do_load(8 * 9, 3, "R6 full store");
        do_store(8 * 9, 3, 64'hFEDC_BA98_7654_3210);
        do_load(8 * 9, 3, "R6 full replace");
        // R4 R5 sweep: every aligned store followed by every aligned load
        for (int w = 16; w < 19; w++) begin
            for (int ssz = 0; ssz < 4; ssz++) begin
                for (int soff = 0; soff < 8; soff += (1 << ssz)) begin
                    do_store(w * 8 + soff, ssz,
                             64'h0123_4567_89AB_CDEF ^ (64'(w * 64 + ssz * 8 + soff) * 64'h9E37_79B9_7F4A_7C15));
                    for (int lsz = 0; lsz < 4; lsz++) begin
                        for (int loff = 0; loff < 8; loff += (1 << lsz)) begin
                            do_load(w * 8 + loff, lsz, "R4 R5 lane sweep");
                        end
                    end
                end
            end
        end
        // R2 R3 all misaligned combinations, stores and loads
        do_store(8 * 30, 3, 64'h1122_3344_5566_7788);
        for (int sz = 1; sz < 4; sz++) begin
            for (int off = 0; off < 8; off++) begin
                if ((off & ((1 << sz) - 1)) != 0) begin
                    held = rd_data;
                    issue(8 * 30 + off, sz, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
                    check("R3 misaligned store err", 64'(misalign_err), 64'h1);
                    check("R3 misaligned store no valid", 64'(rd_valid), 64'h0);
                    check("R8 rd_data held", rd_data, held);
                    issue(8 * 30 + off, sz, 1'b0, 64'h0);
                    check("R3 misaligned load err", 64'(misalign_err), 64'h1);
                    check("R3 misaligned load no valid", 64'(rd_valid), 64'h0);
                    @(negedge clk);
                    check("R3 err one cycle", 64'(misalign_err), 64'h0);
                    do_load(8 * 30, 3, "R3 word unchanged");
                end
            end
        end
        // R7 reset mid-run clears contents
        rst_n = 1'b0;
        @(negedge clk);
        check("R7 rd_valid in reset", 64'(rd_valid), 64'h0);
        check("R7 rd_data in reset", rd_data, 64'h0);
        rst_n = 1'b1;
        for (int i = 0; i < 256; i++) model[i] = '0;
        @(negedge clk);
        do_load(8 * 9, 3, "R7 cleared after reset");
        do_load(8 * 30, 3, "R7 cleared after reset");
        summary();
    end
endmodule